// File: doc/BRIEF.md
# Magic Packet Wake Detector

This block listens to the byte stream that a MAC hands over while the station sleeps, and looks for a wake pattern. The pattern is at least six 0xFF bytes in a row, followed at once by sixteen consecutive copies of the station's own 6-byte node address. The pattern may sit at any offset in the frame. When the frame ends, the block declares a wake only if the pattern was seen, the destination address passed the station's address filter, and the CRC was good.

A declared wake sets a sticky event-status bit. An active-low, open-drain style request line is pulled low while both that status bit and an event-enable bit are 1. A register-style write port loads the detector enable and the event enable. A write-one-to-clear strobe clears the status bit. A power-state strobe marks the move from D3 to D0. That strobe forces the detector enable off but leaves the pending event request alone until software clears it.

Top module: `magic_wake_detect`

## Requirements
- R1: After at least six 0xFF bytes, sixteen back-to-back copies of `nodeAddr` matched byte by byte (bits 47:40 first, bits 7:0 last in each copy) and an end strobe with `addrPass`=1 and `crcOk`=1 set `pmeStatus` on the clock edge that samples `rxEof`. With fifteen copies, no wake is declared.
- R2: The pattern is found whether it starts at the first byte of the frame or at any later byte.
- R3: If `addrPass`=0 or `crcOk`=0 at the end strobe, no wake is declared, even when the pattern was present.
- R4: `cfgWr`=1 loads `magicEnOut` from `cfgMagicEn` and the event enable from `cfgPmeEn`. While `magicEnOut`=0, a frame that carries the pattern leaves `pmeStatus` unchanged.
- R5: A `d3ToD0` pulse clears `magicEnOut` on that edge. It does not change `pmeStatus` or `pmeReqN`.
- R6: `pmeReqN` is 0 exactly when `pmeStatus`=1 and the event enable is 1. Clearing the event enable releases the line to 1 and keeps the status bit.
- R7: A `statusClr` pulse clears `pmeStatus`, and `pmeReqN` returns to 1 in the following cycle. If a wake is declared in the same cycle as the clear, the wake wins and the status stays 1.
- R8: A byte that breaks the address copies sends the matcher back to searching for sync. If that breaking byte is 0xFF, it counts as the first byte of a new sync run.
- R9: A sync run longer than six 0xFF bytes is accepted. The last six bytes of the run form the sync.
- R10: A frame start (`rxSof` with a byte) discards any partial or completed match from the previous frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| rxValid | input | 1 | A received byte is present on `rxData` |
| rxData | input | 8 | Received byte |
| rxSof | input | 1 | With `rxValid`: this byte is the first of a frame |
| rxEof | input | 1 | End-of-frame strobe; a cycle of its own, carries no byte |
| addrPass | input | 1 | Address filter verdict, sampled with `rxEof` |
| crcOk | input | 1 | CRC verdict, sampled with `rxEof` |
| nodeAddr | input | 48 | Station node address, bits 47:40 sent first |
| cfgWr | input | 1 | Write strobe for the two enable bits |
| cfgMagicEn | input | 1 | Detector enable value written by `cfgWr` |
| cfgPmeEn | input | 1 | Event enable value written by `cfgWr` |
| statusClr | input | 1 | Write-one-to-clear pulse for the status bit |
| d3ToD0 | input | 1 | Power state changed from D3 to D0 |
| magicEnOut | output | 1 | Current detector enable |
| pmeStatus | output | 1 | Sticky event-status bit |
| pmeReqN | output | 1 | Event request, active low |

## Verification
The event-status bit can receive a set and a clear in the same clock. The set comes from a wake declared at end of frame, and the clear from the write-one-to-clear strobe. The bench provokes this by raising `statusClr` in the same cycle as an end strobe that qualifies a found pattern. It then expects the status still at 1 and the request line still low. In a separate step it clears the status with no frame ending and expects the bit at 0 and the line released on the next cycle.

// File: rtl/wake_pkg.sv
package wake_pkg;
  // strobes from the control half to the matcher datapath
  typedef struct packed {
    logic run;         // detector enabled: bytes are examined
    logic clearMatch;  // drop any match state this cycle
  } matchCtlT;
endpackage

// File: rtl/wake_matcher.sv
module wake_matcher
  import wake_pkg::*;
#(
  parameter int ADDR_BYTES = 6,
  parameter int SYNC_LEN   = 6,
  parameter int COPIES     = 16
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  matchCtlT                ctl,
  input  logic                    rxValid,
  input  logic [7:0]              rxData,
  input  logic                    rxSof,
  input  logic                    rxEof,
  input  logic                    addrPass,
  input  logic                    crcOk,
  input  logic [ADDR_BYTES*8-1:0] nodeAddr,
  output logic                    wakeHit
);
  localparam int TOTAL  = ADDR_BYTES * COPIES;
  localparam int PTR_W  = $clog2(TOTAL);
  localparam int SUB_W  = (ADDR_BYTES > 1) ? $clog2(ADDR_BYTES) : 1;
  localparam int SYNC_W = $clog2(SYNC_LEN + 1);

  logic [7:0] addrByte [ADDR_BYTES];

  // byte 0 is the first byte on the wire (most significant)
  for (genvar g = 0; g < ADDR_BYTES; g++) begin : gAddrBytes
    assign addrByte[g] = nodeAddr[(ADDR_BYTES-1-g)*8 +: 8];
  end

  logic [SYNC_W-1:0] syncCnt, syncNxt;
  logic [PTR_W-1:0]  addrPtr, ptrNxt;
  logic [SUB_W-1:0]  subIdx, subNxt;
  logic              inAddr, inAddrNxt;
  logic              found, foundNxt;
  logic              sofByte;
  logic              isFf;

  assign sofByte = rxValid & rxSof;
  assign isFf    = (rxData == 8'hFF);

  always_comb begin
    syncNxt   = sofByte ? '0 : syncCnt;
    inAddrNxt = sofByte ? 1'b0 : inAddr;
    ptrNxt    = sofByte ? '0 : addrPtr;
    subNxt    = sofByte ? '0 : subIdx;
    foundNxt  = sofByte ? 1'b0 : found;
    if (rxValid && ctl.run) begin
      if (inAddrNxt) begin
        if (rxData == addrByte[subNxt]) begin
          if (ptrNxt == PTR_W'(TOTAL - 1)) begin
            foundNxt  = 1'b1;
            inAddrNxt = 1'b0;
            syncNxt   = '0;
          end else begin
            ptrNxt = ptrNxt + 1'b1;
            subNxt = (subNxt == SUB_W'(ADDR_BYTES - 1)) ? '0 : subNxt + 1'b1;
          end
        end else begin
          inAddrNxt = 1'b0;
          syncNxt   = isFf ? SYNC_W'(1) : '0;
        end
      end else if (isFf) begin
        syncNxt = (syncNxt == SYNC_W'(SYNC_LEN)) ? syncNxt : syncNxt + 1'b1;
      end else if (syncNxt == SYNC_W'(SYNC_LEN) && rxData == addrByte[0]) begin
        inAddrNxt = 1'b1;
        ptrNxt    = PTR_W'(1);
        subNxt    = SUB_W'(1);
        syncNxt   = '0;
      end else begin
        syncNxt = '0;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      syncCnt <= '0;
      addrPtr <= '0;
      subIdx  <= '0;
      inAddr  <= 1'b0;
      found   <= 1'b0;
    end else if (ctl.clearMatch) begin
      syncCnt <= '0;
      addrPtr <= '0;
      subIdx  <= '0;
      inAddr  <= 1'b0;
      found   <= 1'b0;
    end else begin
      syncCnt <= syncNxt;
      addrPtr <= ptrNxt;
      subIdx  <= subNxt;
      inAddr  <= inAddrNxt;
      found   <= foundNxt;
    end
  end

  assign wakeHit = rxEof & found & addrPass & crcOk & ctl.run;

  // R10: a frame start leaves no match behind
  a_r10_sof_clears_found: assert property (@(posedge clk) disable iff (!rstN)
    (rxValid && rxSof) |=> !found);

  // R1: the copy pointer stays inside the 96-byte window while comparing
  a_r1_ptr_in_window: assert property (@(posedge clk) disable iff (!rstN)
    inAddr |-> (addrPtr != '0 && addrPtr <= PTR_W'(TOTAL - 1)));

  // R8: a wrong byte inside the copies ends the address phase
  a_r8_mismatch_restarts: assert property (@(posedge clk) disable iff (!rstN)
    (inAddr && rxValid && !rxSof && rxData != addrByte[subIdx]) |=> !inAddr);

  // R3: no wake without both frame qualifiers
  a_r3_qualified_only: assert property (@(posedge clk) disable iff (!rstN)
    wakeHit |-> (addrPass && crcOk));
endmodule

// File: rtl/wake_ctrl.sv
module wake_ctrl
  import wake_pkg::*;
(
  input  logic     clk,
  input  logic     rstN,
  input  logic     cfgWr,
  input  logic     cfgMagicEn,
  input  logic     cfgPmeEn,
  input  logic     statusClr,
  input  logic     d3ToD0,
  input  logic     wakeHit,
  output matchCtlT ctl,
  output logic     magicEn,
  output logic     pmeEn,
  output logic     pmeStatus
);
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      magicEn <= 1'b0;
      pmeEn   <= 1'b0;
    end else begin
      if (cfgWr) begin
        magicEn <= cfgMagicEn;
        pmeEn   <= cfgPmeEn;
      end
      if (d3ToD0) magicEn <= 1'b0;  // power-up forces the detector off
    end
  end

  // set has priority over the write-one-to-clear pulse
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)          pmeStatus <= 1'b0;
    else if (wakeHit)   pmeStatus <= 1'b1;
    else if (statusClr) pmeStatus <= 1'b0;
  end

  assign ctl.run        = magicEn;
  assign ctl.clearMatch = ~magicEn;

  // R1: status is sticky
  a_r1_status_sticky: assert property (@(posedge clk) disable iff (!rstN)
    (pmeStatus && !statusClr) |=> pmeStatus);

  // R7: a clear with no wake drops the status
  a_r7_clear_works: assert property (@(posedge clk) disable iff (!rstN)
    (statusClr && !wakeHit) |=> !pmeStatus);

  // R7: a wake beats a simultaneous clear
  a_r7_set_wins: assert property (@(posedge clk) disable iff (!rstN)
    wakeHit |=> pmeStatus);

  // R5: power-up transition disables the detector
  a_r5_d3_disables: assert property (@(posedge clk) disable iff (!rstN)
    d3ToD0 |=> !magicEn);

  // R4: a wake needs the detector enabled
  a_r4_hit_needs_en: assert property (@(posedge clk) disable iff (!rstN)
    wakeHit |-> magicEn);
endmodule

// File: rtl/magic_wake_detect.sv
module magic_wake_detect
  import wake_pkg::*;
#(
  parameter int ADDR_BYTES = 6,
  parameter int SYNC_LEN   = 6,
  parameter int COPIES     = 16
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    rxValid,
  input  logic [7:0]              rxData,
  input  logic                    rxSof,
  input  logic                    rxEof,
  input  logic                    addrPass,
  input  logic                    crcOk,
  input  logic [ADDR_BYTES*8-1:0] nodeAddr,
  input  logic                    cfgWr,
  input  logic                    cfgMagicEn,
  input  logic                    cfgPmeEn,
  input  logic                    statusClr,
  input  logic                    d3ToD0,
  output logic                    magicEnOut,
  output logic                    pmeStatus,
  output logic                    pmeReqN
);
  matchCtlT ctl;
  logic     wakeHit;
  logic     pmeEn;

  wake_matcher #(
    .ADDR_BYTES(ADDR_BYTES), .SYNC_LEN(SYNC_LEN), .COPIES(COPIES)
  ) uMatch (
    .clk(clk), .rstN(rstN), .ctl(ctl),
    .rxValid(rxValid), .rxData(rxData), .rxSof(rxSof), .rxEof(rxEof),
    .addrPass(addrPass), .crcOk(crcOk), .nodeAddr(nodeAddr),
    .wakeHit(wakeHit)
  );

  wake_ctrl uCtrl (
    .clk(clk), .rstN(rstN),
    .cfgWr(cfgWr), .cfgMagicEn(cfgMagicEn), .cfgPmeEn(cfgPmeEn),
    .statusClr(statusClr), .d3ToD0(d3ToD0), .wakeHit(wakeHit),
    .ctl(ctl), .magicEn(magicEnOut), .pmeEn(pmeEn), .pmeStatus(pmeStatus)
  );

  assign pmeReqN = ~(pmeStatus & pmeEn);

  // R6: the line is released whenever the event enable is off
  a_r6_release_when_disabled: assert property (@(posedge clk) disable iff (!rstN)
    (cfgWr && !cfgPmeEn) |=> pmeReqN);
endmodule

// File: tb/sim_magic_wake_detect.sv
`timescale 1ns/1ps
module sim_magic_wake_detect;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        rxValid = 0, rxSof = 0, rxEof = 0, addrPass = 0, crcOk = 0;
  logic [7:0]  rxData = '0;
  logic [47:0] nodeAddr = 48'h021A3C4D5E6F;
  logic        cfgWr = 0, cfgMagicEn = 0, cfgPmeEn = 0, statusClr = 0, d3ToD0 = 0;
  logic        magicEnOut, pmeStatus, pmeReqN;

  always #10 clk = ~clk;  // 50 MHz

  magic_wake_detect u0 (
    .clk(clk), .rstN(rstN), .rxValid(rxValid), .rxData(rxData), .rxSof(rxSof),
    .rxEof(rxEof), .addrPass(addrPass), .crcOk(crcOk), .nodeAddr(nodeAddr),
    .cfgWr(cfgWr), .cfgMagicEn(cfgMagicEn), .cfgPmeEn(cfgPmeEn),
    .statusClr(statusClr), .d3ToD0(d3ToD0),
    .magicEnOut(magicEnOut), .pmeStatus(pmeStatus), .pmeReqN(pmeReqN)
  );

  typedef struct {
    string tag;
    logic  st;
    logic  reqN;
    logic  men;
  } expT;

  expT        expQ[$];
  logic [7:0] frm[$];
  int         nCompared = 0;
  int         nFailed = 0;
  logic       mMagic = 0, mPme = 0, mStatus = 0;
  bit         done = 0;

  // monitor: compare every queued expectation away from the rising edge
  always @(negedge clk) begin
    while (expQ.size() > 0) begin
      expT e;
      e = expQ.pop_front();
      nCompared++;
      if (pmeStatus !== e.st || pmeReqN !== e.reqN || magicEnOut !== e.men) begin
        nFailed++;
        $display("FAIL %s: status/reqN/magicEn got %b%b%b expected %b%b%b",
                 e.tag, pmeStatus, pmeReqN, magicEnOut, e.st, e.reqN, e.men);
      end
    end
  end

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic expectNow(string tag);
    expT e;
    e.tag  = tag;
    e.st   = mStatus;
    e.reqN = ~(mStatus & mPme);
    e.men  = mMagic;
    expQ.push_back(e);
    tick();
  endtask

  task automatic addByte(logic [7:0] b);
    frm.push_back(b);
  endtask

  task automatic addJunk(int n);
    for (int i = 0; i < n; i++) frm.push_back(8'h10 + 8'(i));
  endtask

  task automatic addSync(int n);
    for (int i = 0; i < n; i++) frm.push_back(8'hFF);
  endtask

  task automatic addCopies(int n);
    for (int c = 0; c < n; c++)
      for (int b = 0; b < 6; b++) frm.push_back(nodeAddr[(5-b)*8 +: 8]);
  endtask

  // send the built frame, then an end strobe; expWake is the bench's verdict
  task automatic sendFrame(logic pass, logic crc, logic clr, logic expWake);
    for (int i = 0; i < frm.size(); i++) begin
      rxValid = 1'b1;
      rxData  = frm[i];
      rxSof   = (i == 0);
      tick();
    end
    rxValid = 0; rxSof = 0;
    rxEof = 1; addrPass = pass; crcOk = crc; statusClr = clr;
    tick();
    rxEof = 0; addrPass = 0; crcOk = 0; statusClr = 0;
    if (expWake) mStatus = 1'b1;
    else if (clr) mStatus = 1'b0;
    frm.delete();
  endtask

  task automatic writeCfg(logic m, logic p);
    cfgWr = 1; cfgMagicEn = m; cfgPmeEn = p;
    tick();
    cfgWr = 0;
    mMagic = m; mPme = p;
  endtask

  task automatic clearStatus();
    statusClr = 1;
    tick();
    statusClr = 0;
    mStatus = 0;
  endtask

  task automatic pulseD3();
    d3ToD0 = 1;
    tick();
    d3ToD0 = 0;
    mMagic = 0;
  endtask

  initial begin
    repeat (3) tick();
    rstN = 1'b1;
    tick();
    expectNow("R6 reset state");

    writeCfg(1, 1);
    expectNow("R4 enable write");

    // R1 + R2: pattern after a 12-byte header
    addJunk(12); addSync(6); addCopies(16); addJunk(4);
    sendFrame(1, 1, 0, 1);
    expectNow("R1 wake after header");

    // R7: plain clear releases the line next cycle
    clearStatus();
    expectNow("R7 clear");

    // R3: bad CRC, then failed address filter
    addJunk(3); addSync(6); addCopies(16);
    sendFrame(1, 0, 0, 0);
    expectNow("R3 crc error");
    addJunk(3); addSync(6); addCopies(16);
    sendFrame(0, 1, 0, 0);
    expectNow("R3 address filter fail");

    // R2: pattern at offset 0
    addSync(6); addCopies(16);
    sendFrame(1, 1, 0, 1);
    expectNow("R2 pattern at first byte");
    clearStatus();

    // R1: only fifteen copies
    addJunk(5); addSync(6); addCopies(15); addJunk(6);
    sendFrame(1, 1, 0, 0);
    expectNow("R1 fifteen copies");

    // R6: status with event enable off, then on, then off
    writeCfg(1, 0);
    addSync(6); addCopies(16);
    sendFrame(1, 1, 0, 1);
    expectNow("R6 status with event enable off");
    writeCfg(1, 1);
    expectNow("R6 line driven once enabled");
    writeCfg(1, 0);
    expectNow("R6 line released, status kept");
    writeCfg(1, 1);
    clearStatus();

    // R8: mismatch 0xFF opens a new sync run
    addSync(6); addCopies(5); addByte(8'hFF); addSync(5); addCopies(16);
    sendFrame(1, 1, 0, 1);
    expectNow("R8 mismatching 0xFF starts sync");
    clearStatus();

    // R8: mismatch by another byte needs a full fresh sync
    addSync(6); addCopies(10); addByte(8'h00); addCopies(6);
    sendFrame(1, 1, 0, 0);
    expectNow("R8 mismatch then copies only");

    // R9: long sync run
    addJunk(2); addSync(9); addCopies(16);
    sendFrame(1, 1, 0, 1);
    expectNow("R9 nine 0xFF sync");
    clearStatus();

    // R10: partial match does not survive a frame start
    addSync(6); addCopies(8);
    sendFrame(1, 1, 0, 0);
    addCopies(8);
    sendFrame(1, 1, 0, 0);
    expectNow("R10 no carry across frames");

    // R4: detector disabled
    writeCfg(0, 1);
    addSync(6); addCopies(16);
    sendFrame(1, 1, 0, 0);
    expectNow("R4 detector off");

    // R5: power-up transition
    writeCfg(1, 1);
    addSync(6); addCopies(16);
    sendFrame(1, 1, 0, 1);
    pulseD3();
    expectNow("R5 d3 to d0 keeps request");
    clearStatus();
    addSync(6); addCopies(16);
    sendFrame(1, 1, 0, 0);
    expectNow("R5 detector stays off after d3");

    // R7: wake and clear in the same cycle
    writeCfg(1, 1);
    addSync(6); addCopies(16);
    sendFrame(1, 1, 1, 1);
    expectNow("R7 wake beats clear");
    clearStatus();
    expectNow("R7 clear after collision");

    tick();
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nCompared, nFailed);
    $finish;
  end

  initial begin
    #(200000 * 20);
    if (!done) begin
      nCompared++;
      nFailed++;
      $display("FAIL watchdog: run did not finish, got hung expected done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nCompared, nFailed);
      $finish;
    end
  end
endmodule